// File: doc/BRIEF.md
# Host Request to Memory-Mapped Master Bridge

This block turns decoded inbound memory requests from a host link into transactions on a memory-mapped master port. A request arrives in one handshake. It gives a direction, a byte address, a length in 32-bit words, an enable nibble for the first word and another for the last word. For writes, the payload follows as a stream of bus-wide beats on a separate data input. The bridge drives read and write strobes, a word address, a word count, byte enables and write data, and it obeys the slave's stall signal. Read data comes back as one response per returned beat.

A build-time switch picks one of two variants. The strict variant has a 32-bit data path and forwards only single-word accesses. The bursting variant has a 128-bit data path and forwards accesses of 1 to 63 words. Any request that the chosen variant cannot serve is never issued on the master port. Instead it receives an abort response. Only one request is in flight at any time.

Top module: `req_mm_bridge`

## Requirements
- R1: After reset, `reqReady` is 1 and `mmRead`, `mmWrite` and `rspValid` are all 0.
- R2: `mmAddress` is the request address with bits [1:0] forced to 0. In the strict variant (BURST_EN=0), a one-word access is forwarded with `mmBurstCount` = 1 and `mmByteEnable` = `reqFirstBe`.
- R3: A request is unsupported if its length is 0, if its length is above 63, or if BURST_EN=0 and its length is not 1. An unsupported request raises `rspValid` for exactly the cycle after acceptance, with `rspStatus` = 2'b10 and `rspLast` = 1. It produces no `mmRead` or `mmWrite`, and `reqReady` is 1 again in that cycle.
- R4: In the bursting variant, any length from 1 to 63 is forwarded, and `mmBurstCount` equals the length in words.
- R5: A write issues N beats in the order of the `wdData` beats accepted with `wdValid`/`wdReady`. N = ceil((off + len) / L), where L is the number of words per beat (4 in the bursting variant, 1 in the strict variant). The offset off is `reqAddr[3:2]` when L = 4 and 0 otherwise.
- R6: Word lanes are numbered from the start of beat 0, so lane p of beat b is word b*L+p. Word k of the request (k = 0 .. len-1) sits in lane off+k. The bytes of word k are enabled by `reqFirstBe` when k = 0, by `reqLastBe` when k = len-1 and k > 0, and fully (4'hF) otherwise. Lanes outside the request have enables of 0.
- R7: While `mmWaitRequest` is 1 with a strobe raised, the next cycle keeps the same strobe, address, word count, byte enables and write data.
- R8: A read produces exactly N responses, each on the cycle after `mmReadDataValid` was 1. Each carries that beat's `mmReadData` and `rspStatus` = 2'b00, and `rspLast` is set only on the final one.
- R9: `reqReady` stays 0 from an accepted supported request until its last write beat is taken or its last read beat has returned.
- R10: `mmRead` and `mmWrite` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Bridge is idle and takes a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqLen | input | LEN_W | Length in 32-bit words |
| reqFirstBe | input | 4 | Byte enables of the first word |
| reqLastBe | input | 4 | Byte enables of the last word |
| wdValid | input | 1 | Write beat offered |
| wdReady | output | 1 | Write beat taken |
| wdData | input | DATA_W | Lane-aligned write beat |
| rspValid | output | 1 | Response present (one cycle) |
| rspStatus | output | 2 | 2'b00 success, 2'b10 abort |
| rspData | output | DATA_W | Read beat |
| rspLast | output | 1 | Final response of the request |
| mmRead | output | 1 | Read strobe |
| mmWrite | output | 1 | Write strobe |
| mmAddress | output | ADDR_W | Byte address, bits [1:0] zero |
| mmBurstCount | output | 6 | Transfer size in words |
| mmByteEnable | output | DATA_W/8 | Byte enables of the current beat |
| mmWriteData | output | DATA_W | Write beat |
| mmReadData | input | DATA_W | Returned read beat |
| mmReadDataValid | input | 1 | Returned beat is valid |
| mmWaitRequest | input | 1 | Slave stalls the command or beat |

## Verification
The hardest case to reach is a stall that falls on a write beat while the next payload beat is already waiting. The staged beat must stay frozen, and the following beat must only be loaded in the same cycle the stalled one is taken. The hardest read case is a word count that starts in lane 3 and spills into an extra beat. The stimulus drives the stall input and the gaps in the payload and read-return streams from a free-running shift register. It sweeps every lane offset against lengths that end in every lane, up to 63 words. Between beats, the read-data bus carries junk values, so any capture made while the data is not valid shows up in the responses.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RDCMD,
    ST_RDWAIT
  } bridgeState_e;

  localparam logic [1:0] RSP_OK    = 2'b00;
  localparam logic [1:0] RSP_ABORT = 2'b10;

  localparam int MAX_LEN_DW = 63;
  localparam int IDX_W      = 7;

  typedef struct packed {
    logic             capHdr;
    logic             loadBeat;
    logic             capRsp;
    logic             abort;
    logic             lastRsp;
    logic [IDX_W-1:0] beatIdx;
  } dpStrobe_t;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter bit BURST_EN = 1'b1,
  parameter int LEN_W    = 10,
  parameter int LANES    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [1:0]       reqOff,
  input  logic             wdValid,
  output logic             wdReady,
  output logic             mmRead,
  output logic             mmWrite,
  input  logic             mmWaitRequest,
  input  logic             mmReadDataValid,
  output dpStrobe_t        strb
);

  localparam int LANE_SH = (LANES > 1) ? $clog2(LANES) : 0;

  bridgeState_e     state;
  logic [IDX_W-1:0] beatsTotal;
  logic [IDX_W-1:0] loadCnt;
  logic [IDX_W-1:0] ackCnt;
  logic             beatFull;

  logic             accept;
  logic             lenBad;
  logic             wrAcc;
  logic             loadNow;
  logic             lastAck;
  logic [7:0]       spanDw;
  logic [IDX_W-1:0] beatsReq;

  // Classify the request against the variant's limits
  always_comb begin
    lenBad = (reqLen == '0) || (reqLen > LEN_W'(MAX_LEN_DW));
    if (!BURST_EN && (reqLen != LEN_W'(1))) lenBad = 1'b1;
  end

  // Beats spanned by the request once the lane offset is counted
  always_comb begin
    spanDw   = {6'b0, reqOff} + {2'b0, reqLen[5:0]} + 8'(LANES - 1);
    beatsReq = IDX_W'(spanDw >> LANE_SH);
  end

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign mmRead   = (state == ST_RDCMD);
  assign mmWrite  = (state == ST_WRITE) && beatFull;
  assign wrAcc    = mmWrite && !mmWaitRequest;
  assign wdReady  = (state == ST_WRITE) && (loadCnt != beatsTotal) &&
                    (!beatFull || wrAcc);
  assign loadNow  = wdReady && wdValid;
  assign lastAck  = (ackCnt == beatsTotal - IDX_W'(1));

  always_comb begin
    strb          = '0;
    strb.capHdr   = accept && !lenBad;
    strb.abort    = accept && lenBad;
    strb.loadBeat = loadNow;
    strb.beatIdx  = loadCnt;
    strb.capRsp   = (state == ST_RDWAIT) && mmReadDataValid;
    strb.lastRsp  = (state == ST_RDWAIT) && mmReadDataValid && lastAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatsTotal <= '0;
      loadCnt    <= '0;
      ackCnt     <= '0;
      beatFull   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && !lenBad) begin
            beatsTotal <= beatsReq;
            loadCnt    <= '0;
            ackCnt     <= '0;
            beatFull   <= 1'b0;
            state      <= reqWrite ? ST_WRITE : ST_RDCMD;
          end
        end
        ST_WRITE: begin
          if (loadNow) loadCnt <= loadCnt + IDX_W'(1);
          if (loadNow)    beatFull <= 1'b1;
          else if (wrAcc) beatFull <= 1'b0;
          if (wrAcc) begin
            ackCnt <= ackCnt + IDX_W'(1);
            if (lastAck) state <= ST_IDLE;
          end
        end
        ST_RDCMD: begin
          if (!mmWaitRequest) state <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (mmReadDataValid) begin
            ackCnt <= ackCnt + IDX_W'(1);
            if (lastAck) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-3:0] reqDwAddr,
  input  logic [5:0]        reqLenDw,
  input  logic [3:0]        reqFirstBe,
  input  logic [3:0]        reqLastBe,
  input  logic [1:0]        reqOff,
  input  logic [DATA_W-1:0] wdData,
  output logic [ADDR_W-1:0] mmAddress,
  output logic [5:0]        mmBurstCount,
  output logic [DATA_W/8-1:0] mmByteEnable,
  output logic [DATA_W-1:0] mmWriteData,
  input  logic [DATA_W-1:0] mmReadData,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLast
);

  localparam int LANES = DATA_W / 32;
  localparam int BE_W  = DATA_W / 8;

  logic [ADDR_W-3:0] addrQ;
  logic [5:0]        lenQ;
  logic [3:0]        fbeQ;
  logic [3:0]        lbeQ;
  logic [1:0]        offQ;
  logic [BE_W-1:0]   beQ;
  logic [DATA_W-1:0] dataQ;

  logic [IDX_W-1:0]  selIdx;
  logic [1:0]        selOff;
  logic [5:0]        selLen;
  logic [3:0]        selFbe;
  logic [3:0]        selLbe;
  logic [7:0]        firstPos;
  logic [7:0]        lastPos;
  logic [BE_W-1:0]   beCalc;

  // At header capture the enables of beat 0 come from the live request
  always_comb begin
    if (strb.capHdr) begin
      selIdx = '0;
      selOff = reqOff;
      selLen = reqLenDw;
      selFbe = reqFirstBe;
      selLbe = reqLastBe;
    end else begin
      selIdx = strb.beatIdx;
      selOff = offQ;
      selLen = lenQ;
      selFbe = fbeQ;
      selLbe = lbeQ;
    end
    firstPos = {6'b0, selOff};
    lastPos  = {6'b0, selOff} + {2'b0, selLen} - 8'd1;
  end

  // One enable nibble per word lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneAbs;
    logic       inSpan;
    always_comb begin
      laneAbs = 8'(int'(selIdx) * LANES + l);
      inSpan  = (laneAbs >= firstPos) && (laneAbs <= lastPos);
      if (!inSpan)                beCalc[l*4 +: 4] = 4'h0;
      else if (laneAbs == firstPos) beCalc[l*4 +: 4] = selFbe;
      else if (laneAbs == lastPos)  beCalc[l*4 +: 4] = selLbe;
      else                        beCalc[l*4 +: 4] = 4'hF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      lenQ  <= '0;
      fbeQ  <= '0;
      lbeQ  <= '0;
      offQ  <= '0;
      beQ   <= '0;
      dataQ <= '0;
    end else if (strb.capHdr) begin
      addrQ <= reqDwAddr;
      lenQ  <= reqLenDw;
      fbeQ  <= reqFirstBe;
      lbeQ  <= reqLastBe;
      offQ  <= reqOff;
      beQ   <= beCalc;
      dataQ <= '0;
    end else if (strb.loadBeat) begin
      beQ   <= beCalc;
      dataQ <= wdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspStatus <= RSP_OK;
      rspData   <= '0;
      rspLast   <= 1'b0;
    end else begin
      rspValid <= strb.capRsp || strb.abort;
      if (strb.capRsp) begin
        rspStatus <= RSP_OK;
        rspData   <= mmReadData;
        rspLast   <= strb.lastRsp;
      end else if (strb.abort) begin
        rspStatus <= RSP_ABORT;
        rspData   <= '0;
        rspLast   <= 1'b1;
      end
    end
  end

  assign mmAddress    = {addrQ, 2'b00};
  assign mmBurstCount = lenQ;
  assign mmByteEnable = beQ;
  assign mmWriteData  = dataQ;

endmodule

// File: rtl/req_mm_bridge.sv
module req_mm_bridge
  import bridge_pkg::*;
#(
  parameter bit BURST_EN = 1'b1,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 10,
  localparam int DATA_W  = BURST_EN ? 128 : 32,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [3:0]        reqFirstBe,
  input  logic [3:0]        reqLastBe,
  input  logic              wdValid,
  output logic              wdReady,
  input  logic [DATA_W-1:0] wdData,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLast,
  output logic              mmRead,
  output logic              mmWrite,
  output logic [ADDR_W-1:0] mmAddress,
  output logic [5:0]        mmBurstCount,
  output logic [BE_W-1:0]   mmByteEnable,
  output logic [DATA_W-1:0] mmWriteData,
  input  logic [DATA_W-1:0] mmReadData,
  input  logic              mmReadDataValid,
  input  logic              mmWaitRequest
);

  localparam int LANES = DATA_W / 32;

  dpStrobe_t  strb;
  logic [1:0] reqOff;

  assign reqOff = (LANES > 1) ? reqAddr[3:2] : 2'b00;

  bridge_ctrl #(
    .BURST_EN(BURST_EN),
    .LEN_W   (LEN_W),
    .LANES   (LANES)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqReady       (reqReady),
    .reqWrite       (reqWrite),
    .reqLen         (reqLen),
    .reqOff         (reqOff),
    .wdValid        (wdValid),
    .wdReady        (wdReady),
    .mmRead         (mmRead),
    .mmWrite        (mmWrite),
    .mmWaitRequest  (mmWaitRequest),
    .mmReadDataValid(mmReadDataValid),
    .strb           (strb)
  );

  bridge_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqDwAddr   (reqAddr[ADDR_W-1:2]),
    .reqLenDw    (reqLen[5:0]),
    .reqFirstBe  (reqFirstBe),
    .reqLastBe   (reqLastBe),
    .reqOff      (reqOff),
    .wdData      (wdData),
    .mmAddress   (mmAddress),
    .mmBurstCount(mmBurstCount),
    .mmByteEnable(mmByteEnable),
    .mmWriteData (mmWriteData),
    .mmReadData  (mmReadData),
    .rspValid    (rspValid),
    .rspStatus   (rspStatus),
    .rspData     (rspData),
    .rspLast     (rspLast)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter bit BURST_EN = 1'b1,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 10,
  parameter int DATA_W   = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [LEN_W-1:0]  reqLen,
  input logic              mmRead,
  input logic              mmWrite,
  input logic              mmWaitRequest,
  input logic [ADDR_W-1:0] mmAddress,
  input logic [5:0]        mmBurstCount,
  input logic [DATA_W/8-1:0] mmByteEnable,
  input logic [DATA_W-1:0] mmWriteData,
  input logic              mmReadDataValid,
  input logic              rspValid,
  input logic [1:0]        rspStatus
);

  logic reqBad;
  assign reqBad = (reqLen == '0) || (reqLen > LEN_W'(63)) ||
                  (!BURST_EN && (reqLen != LEN_W'(1)));

  // R10
  excl_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mmRead && mmWrite));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmWrite && mmWaitRequest |=> mmWrite && $stable(mmAddress) &&
      $stable(mmWriteData) && $stable(mmByteEnable) && $stable(mmBurstCount));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmRead && mmWaitRequest |=> mmRead && $stable(mmAddress) &&
      $stable(mmByteEnable) && $stable(mmBurstCount));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mmRead || mmWrite) |-> (mmAddress[1:0] == 2'b00));

  // R9
  one_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mmRead || mmWrite) |-> !reqReady);

  // R3
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqBad |=>
      rspValid && (rspStatus == 2'b10) && !mmRead && !mmWrite && reqReady);

  // R8
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspStatus == 2'b00) |-> $past(mmReadDataValid));

  // R4
  bc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mmRead || mmWrite) |-> (mmBurstCount != 6'd0) &&
      (BURST_EN || (mmBurstCount == 6'd1)));

endmodule

bind req_mm_bridge bridge_chk #(
  .BURST_EN(BURST_EN),
  .ADDR_W  (ADDR_W),
  .LEN_W   (LEN_W),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/sim_req_mm_bridge.sv
module sim_req_mm_bridge;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  // shared request / stream / slave inputs
  logic         reqValid0 = 0, reqValid1 = 0;
  logic         reqWrite = 0;
  logic [31:0]  reqAddr = 0;
  logic [9:0]   reqLen = 0;
  logic [3:0]   reqFirstBe = 0, reqLastBe = 0;
  logic         wdValid = 0;
  logic [127:0] wdData = 0;
  logic [127:0] mmReadData = 0;
  logic         mmReadDataValid = 0;
  logic         mmWaitRequest = 0;

  // bursting instance outputs
  logic         rr0, wr0, rv0, rl0, mr0, mw0;
  logic [1:0]   rs0;
  logic [127:0] rd0, wd0;
  logic [31:0]  ma0;
  logic [5:0]   bc0;
  logic [15:0]  be0;
  // strict instance outputs
  logic         rr1, wr1, rv1, rl1, mr1, mw1;
  logic [1:0]   rs1;
  logic [31:0]  rd1, wd1;
  logic [31:0]  ma1;
  logic [5:0]   bc1;
  logic [3:0]   be1;

  req_mm_bridge u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid0), .reqReady(rr0),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqFirstBe(reqFirstBe), .reqLastBe(reqLastBe),
    .wdValid(wdValid), .wdReady(wr0), .wdData(wdData),
    .rspValid(rv0), .rspStatus(rs0), .rspData(rd0), .rspLast(rl0),
    .mmRead(mr0), .mmWrite(mw0), .mmAddress(ma0), .mmBurstCount(bc0),
    .mmByteEnable(be0), .mmWriteData(wd0), .mmReadData(mmReadData),
    .mmReadDataValid(mmReadDataValid), .mmWaitRequest(mmWaitRequest));

  req_mm_bridge #(.BURST_EN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid1), .reqReady(rr1),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqFirstBe(reqFirstBe), .reqLastBe(reqLastBe),
    .wdValid(wdValid), .wdReady(wr1), .wdData(wdData[31:0]),
    .rspValid(rv1), .rspStatus(rs1), .rspData(rd1), .rspLast(rl1),
    .mmRead(mr1), .mmWrite(mw1), .mmAddress(ma1), .mmBurstCount(bc1),
    .mmByteEnable(be1), .mmWriteData(wd1), .mmReadData(mmReadData[31:0]),
    .mmReadDataValid(mmReadDataValid), .mmWaitRequest(mmWaitRequest));

  // selected instance view
  bit sel = 0;
  logic         sReqReady, sWdReady, sRspValid, sRspLast, sRead, sWrite;
  logic [1:0]   sRspStatus;
  logic [127:0] sRspData, sWd;
  logic [31:0]  sAddr;
  logic [5:0]   sBc;
  logic [15:0]  sBe;
  always_comb begin
    sReqReady  = sel ? rr1 : rr0;
    sWdReady   = sel ? wr1 : wr0;
    sRspValid  = sel ? rv1 : rv0;
    sRspLast   = sel ? rl1 : rl0;
    sRspStatus = sel ? rs1 : rs0;
    sRspData   = sel ? {96'b0, rd1} : rd0;
    sRead      = sel ? mr1 : mr0;
    sWrite     = sel ? mw1 : mw0;
    sAddr      = sel ? ma1 : ma0;
    sBc        = sel ? bc1 : bc0;
    sBe        = sel ? {12'b0, be1} : be0;
    sWd        = sel ? {96'b0, wd1} : wd0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] wdPat(input int tagv, input int i);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) w[k*32 +: 32] = {8'(tagv), 8'(i), 8'(k), 8'h5A};
    return w;
  endfunction

  function automatic logic [127:0] rdPat(input logic [31:0] a, input int b);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) w[k*32 +: 32] = a ^ {16'hC0DE, 8'(b), 8'(k)};
    return w;
  endfunction

  function automatic logic [15:0] expBe(input int lanes, input int off, input int len,
                                        input logic [3:0] fbe, input logic [3:0] lbe,
                                        input int beat);
    logic [15:0] e = '0;
    for (int j = 0; j < lanes; j++) begin
      int pos = beat * lanes + j - off;
      if (pos >= 0 && pos < len) begin
        if (pos == 0)            e[j*4 +: 4] = fbe;
        else if (pos == len - 1) e[j*4 +: 4] = lbe;
        else                     e[j*4 +: 4] = 4'hF;
      end
    end
    return e;
  endfunction

  // slave / monitor state
  bit           waitOn = 0;
  logic [15:0]  lfsr = 16'hACE1;
  int           wrN = 0, rspN = 0, rdCmdN = 0, rdSent = 0, rdLeft = 0, rdBeat = 0;
  logic [31:0]  wrAddrL[32];
  logic [5:0]   wrBcL[32];
  logic [15:0]  wrBeL[32];
  logic [127:0] wrDataL[32];
  logic [127:0] rspDL[32];
  logic [1:0]   rspSL[32];
  logic         rspLL[32];
  logic [31:0]  rdAddr = 0;
  logic [5:0]   rdBc = 0;
  logic [15:0]  rdBe = 0;
  logic         pWait = 0, pRead = 0, pWrite = 0;
  logic [31:0]  pAddr = 0;
  logic [5:0]   pBc = 0;
  logic [15:0]  pBe = 0;
  logic [127:0] pWd = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sRspValid && rspN < 32) begin
        rspDL[rspN] = sRspData; rspSL[rspN] = sRspStatus; rspLL[rspN] = sRspLast;
        rspN++;
      end
      if (pWait && (pRead || pWrite))
        chk(sRead == pRead && sWrite == pWrite && sAddr == pAddr && sBc == pBc &&
            sBe == pBe && sWd == pWd, "R7", "stalled command changed",
            {sRead, sWrite, sAddr, sBe}, {pRead, pWrite, pAddr, pBe});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mmWaitRequest = waitOn && lfsr[0];
      mmReadDataValid = 0;
      mmReadData = {4{lfsr, ~lfsr}};
      if (rdLeft > 0 && (!waitOn || lfsr[3])) begin
        mmReadDataValid = 1;
        mmReadData = rdPat(rdAddr, rdBeat);
        rdBeat++; rdLeft--; rdSent++;
      end
      if (sRead && sWrite) chk(0, "R10", "both strobes", 1, 0);
      if (sWrite && !mmWaitRequest && wrN < 32) begin
        wrAddrL[wrN] = sAddr; wrBcL[wrN] = sBc; wrBeL[wrN] = sBe; wrDataL[wrN] = sWd;
        wrN++;
      end
      if (sRead && !mmWaitRequest) begin
        int lanes = sel ? 1 : 4;
        int off   = sel ? 0 : int'(sAddr[3:2]);
        rdCmdN++; rdAddr = sAddr; rdBc = sBc; rdBe = sBe;
        rdLeft = (off + int'(sBc) + lanes - 1) / lanes; rdBeat = 0;
      end
      pWait = mmWaitRequest; pRead = sRead; pWrite = sWrite;
      pAddr = sAddr; pBc = sBc; pBe = sBe; pWd = sWd;
    end
  end

  // write payload feeder
  bit feedOn = 0;
  int feedN = 0, wdIdx = 0, tag = 0;
  always begin
    @(negedge clk);
    #2;
    wdValid = feedOn && (wdIdx < feedN) && (!waitOn || lfsr[5]);
    wdData  = wdPat(tag, wdIdx);
    #2;
    if (wdValid && sWdReady) wdIdx++;
  end

  task automatic doReq(input bit isWr, input logic [31:0] addr, input int len,
                       input logic [3:0] fbe, input logic [3:0] lbe);
    int lanes = sel ? 1 : 4;
    int off   = sel ? 0 : int'(addr[3:2]);
    bit bad   = (len == 0) || (len > 63) || (sel && len != 1);
    int nb    = bad ? 0 : (off + len + lanes - 1) / lanes;
    int guard = 0;
    logic [31:0] eAddr = {addr[31:2], 2'b00};
    logic [127:0] mask = sel ? 128'hFFFF_FFFF : {128{1'b1}};
    @(negedge clk);
    #1;
    wrN = 0; rspN = 0; rdCmdN = 0; rdSent = 0; tag++; wdIdx = 0;
    feedN = (isWr && !bad) ? nb : 0; feedOn = isWr;
    reqWrite = isWr; reqAddr = addr; reqLen = 10'(len);
    reqFirstBe = fbe; reqLastBe = lbe;
    if (sel) reqValid1 = 1; else reqValid0 = 1;
    @(posedge clk);
    #1;
    reqValid0 = 0; reqValid1 = 0;
    do begin
      @(negedge clk);
      #3;
      guard++;
    end while (!sReqReady && guard < 600);
    chk(guard < 600, "R9", "request never completed", guard, 600);
    if (!bad && isWr) chk(wrN == nb, "R9", "ready before all write beats", wrN, nb);
    if (!bad && !isWr) chk(rdSent == nb, "R9", "ready before all read beats", rdSent, nb);
    repeat (3) @(negedge clk);
    #3;
    feedOn = 0;
    if (bad) begin
      chk(rspN == 1, "R3", "abort response count", rspN, 1);
      if (rspN > 0)
        chk(rspSL[0] == 2'b10 && rspLL[0], "R3", "abort status/last",
            {rspSL[0], rspLL[0]}, {2'b10, 1'b1});
      chk(wrN == 0 && rdCmdN == 0, "R3", "abort reached master port",
          wrN + rdCmdN, 0);
    end else if (isWr) begin
      chk(wrN == nb, "R5", "write beat count", wrN, nb);
      chk(rspN == 0, "R5", "response on write", rspN, 0);
      for (int b = 0; b < nb && b < wrN; b++) begin
        chk(wrAddrL[b] == eAddr, "R2", "write address", wrAddrL[b], eAddr);
        chk(int'(wrBcL[b]) == len, "R4", "write word count", wrBcL[b], len);
        chk(wrBeL[b] == expBe(lanes, off, len, fbe, lbe, b), "R6", "write enables",
            wrBeL[b], expBe(lanes, off, len, fbe, lbe, b));
        chk(wrDataL[b] == (wdPat(tag, b) & mask), "R5", "write beat data",
            wrDataL[b], wdPat(tag, b) & mask);
      end
    end else begin
      chk(rdCmdN == 1, "R4", "read command count", rdCmdN, 1);
      chk(rdAddr == eAddr && int'(rdBc) == len, "R2", "read address/count",
          {rdAddr, rdBc}, {eAddr, 6'(len)});
      chk(rdBe == expBe(lanes, off, len, fbe, lbe, 0), "R2", "read enables",
          rdBe, expBe(lanes, off, len, fbe, lbe, 0));
      chk(rspN == nb, "R8", "read response count", rspN, nb);
      for (int b = 0; b < nb && b < rspN; b++)
        chk(rspDL[b] == (rdPat(eAddr, b) & mask) && rspSL[b] == 2'b00 &&
            rspLL[b] == (b == nb - 1), "R8", "read response",
            {rspSL[b], rspLL[b], rspDL[b]},
            {2'b00, b == nb - 1, rdPat(eAddr, b) & mask});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog expired");
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    int lens[9] = '{1, 2, 3, 4, 5, 6, 8, 13, 63};
    int it = 0;
    repeat (5) @(posedge clk);
    #1;
    chk(rr0 && rr1 && !mr0 && !mw0 && !rv0 && !mr1 && !mw1 && !rv1, "R1",
        "state while in reset", {rr0, rr1, mr0, mw0, rv0}, 5'b11000);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(rr0 && rr1 && !mr0 && !mw0 && !rv0 && !mr1 && !mw1 && !rv1, "R1",
        "state after reset", {rr0, rr1, mr0, mw0, rv0}, 5'b11000);

    // bursting variant: all offsets against lengths ending in every lane
    sel = 0;
    foreach (lens[i]) begin
      for (int off = 0; off < 4; off++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] a = 32'h0001_2000 + 32'(i * 1024) + 32'(off * 4) + 32'(it % 4);
          waitOn = it[0] ^ it[2];
          doReq(w[0], a, lens[i], 4'(4'hF << off), 4'(4'hF >> off));
          it++;
        end
      end
    end
    // bursting variant: unsupported lengths (R3)
    waitOn = 1;
    doReq(1, 32'h40, 0, 4'hF, 4'hF);
    doReq(0, 32'h44, 64, 4'hF, 4'hF);
    doReq(1, 32'h48, 1023, 4'hF, 4'hF);
    doReq(0, 32'h4C, 0, 4'hF, 4'hF);

    // strict variant: single words across offsets and enables
    sel = 1;
    for (int off = 0; off < 4; off++) begin
      for (int w = 0; w < 2; w++) begin
        for (int s = 0; s < 2; s++) begin
          waitOn = s[0];
          doReq(w[0], 32'h0008_0000 + 32'(off * 4) + 32'(s), 1,
                4'(4'b0101 << off), 4'h0);
        end
      end
    end
    // strict variant: anything but one word is aborted (R3)
    doReq(1, 32'h100, 2, 4'hF, 4'hF);
    doReq(0, 32'h104, 4, 4'hF, 4'hF);
    doReq(1, 32'h108, 0, 4'hF, 4'hF);
    doReq(0, 32'h10C, 63, 4'hF, 4'hF);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule